// File: doc/BRIEF.md
# Bidirectional LCD Row Scan Shifter

This block is the common-side scan engine of a dot-matrix LCD driver. A single "selected" bit (the scan token) is loaded from an edge pin and moves one row per line period. Each move happens on the falling edge of the line-pulse input. The chain is 160 rows long by default. It runs either as one long chain or as two independent halves. The shift direction can be reversed. The pins at the chain ends and at the midpoint swap between input and output roles to match, so several devices can be cascaded.

Every row produces a two-bit drive-level code. The code is built from the frame polarity signal and the row's scan bit. An active-low blanking input overrides every row to the lowest level. The analog output stages are outside this block. They consume the level codes.

The line pulse is sampled by the system clock. A falling edge seen between two clock samples triggers one shift at the second sample. Mode and direction inputs are read at the moment of each shift, so a change applies from the next shift onward. A mode change never reorders the stored rows.

Top module: `lcd_row_scan`

## Requirements
- R1: Reset (synchronous, active high) clears every row stage. All output pins then read 0 and no row shows a selected level.
- R2: Stages change only on a clock edge where `line_pulse` was 1 at the previous edge and is 0 now. Holding the pulse high or low, or a rising edge, leaves all rows unchanged.
- R3: In single mode with `scan_up`=1, the bit on `pin_in[0]` enters row 1 and each shift moves the contents one row toward row N. Row N's bit drives `pin_out[3]`, so a token entered on shift 1 appears there after shift N.
- R4: In single mode with `scan_up`=0, the bit on `pin_in[3]` enters row N and each shift moves the contents toward row 1. Row 1's bit drives `pin_out[0]`.
- R5: In dual mode with `scan_up`=1, the lower half takes `pin_in[0]` into row 1 and exits on `pin_out[1]` from row N/2. The upper half takes `pin_in[2]` into row N/2+1 and exits on `pin_out[3]` from row N. No bit crosses between the halves.
- R6: In dual mode with `scan_up`=0, the upper half takes `pin_in[3]` into row N and exits on `pin_out[2]` from row N/2+1. The lower half takes `pin_in[1]` into row N/2 and exits on `pin_out[0]` from row 1.
- R7: Row i's code `row_lvl[2i+1:2i]` (rows counted from 0 in the vector) depends on `frame` and the row bit as follows. Frame 0, bit 0 gives 2 (V4). Frame 0, bit 1 gives 0 (V0). Frame 1, bit 0 gives 1 (V1). Frame 1, bit 1 gives 3 (V5).
- R8: While `blank_n`=0, every row code is 3 (V5) and the stored rows are kept. They show again when `blank_n` returns to 1.
- R9: `pin_oe` marks the output pins for each mode: single up 4'b1000, single down 4'b0001, dual up 4'b1010, dual down 4'b0101. A pin not marked drives 0 on `pin_out`.
- R10: A change of `scan_up` or `dual_half` does not alter the stored rows. It applies from the next shift.
- R11: Values on the pins that are not inputs in the current mode have no effect on the rows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| line_pulse | input | 1 | Line pulse; its falling edge shifts the chain |
| scan_up | input | 1 | 1: rows move toward row N; 0: toward row 1 |
| dual_half | input | 1 | 1: two independent halves; 0: one chain |
| frame | input | 1 | Frame polarity for level coding |
| blank_n | input | 1 | Active-low blanking, forces all codes to V5 |
| pin_in | input | 4 | Token inputs at row 1 end, row N/2, row N/2+1, row N end |
| pin_out | output | 4 | Token outputs at the same four positions |
| pin_oe | output | 4 | Output-role flag for each of the four pins |
| row_lvl | output | 2*N_ROWS | Two-bit drive code per row |

## Verification
A wrong stage bit shows on `row_lvl` at the next sample after the shift that created it. This happens because the level codes decode each row combinationally, so the bench compares the whole row vector against its own model after every shift. A fault in direction, half-split or pin routing is also visible without delay. A corrupted midpoint link shows a token appearing in or missing from the other half one shift later. A wrong pin role shows at once on `pin_oe`/`pin_out`. Bits that reach a chain end show on the exit pin when the token gets there. Noise deliberately placed on the pins that are not inputs in the current mode exposes any input decoding error as a spurious token within one shift.

// File: rtl/row_scan_pkg.sv
package row_scan_pkg;

    localparam int PIN_COUNT  = 4;
    localparam int PIN_LO_END = 0;
    localparam int PIN_MID_LO = 1;
    localparam int PIN_MID_HI = 2;
    localparam int PIN_HI_END = 3;

    // drive level codes, highest rail first
    typedef enum logic [1:0] {
        LVL_TOP    = 2'd0,
        LVL_UPPER  = 2'd1,
        LVL_LOWER  = 2'd2,
        LVL_BOTTOM = 2'd3
    } row_lvl_e;

    typedef struct packed {
        logic dual;
        logic up;
    } scan_mode_t;

    function automatic row_lvl_e row_encode(input logic frm, input logic sel,
                                            input logic on_n);
        row_lvl_e r;
        if (!on_n) begin
            r = LVL_BOTTOM;
        end else begin
            case ({frm, sel})
                2'b00:   r = LVL_LOWER;
                2'b01:   r = LVL_TOP;
                2'b10:   r = LVL_UPPER;
                default: r = LVL_BOTTOM;
            endcase
        end
        return r;
    endfunction

    function automatic logic [PIN_COUNT-1:0] pin_roles(input scan_mode_t m);
        logic [PIN_COUNT-1:0] oe;
        oe = '0;
        if (m.up) begin
            oe[PIN_HI_END] = 1'b1;
            oe[PIN_MID_LO] = m.dual;
        end else begin
            oe[PIN_LO_END] = 1'b1;
            oe[PIN_MID_HI] = m.dual;
        end
        return oe;
    endfunction

endpackage

// File: rtl/row_scan_ctrl.sv
module row_scan_ctrl
    import row_scan_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       line_pulse,
    input  logic       scan_up,
    input  logic       dual_half,
    output logic       shift,
    output scan_mode_t mode
);
    logic lp_q;

    always_ff @(posedge clk) begin
        if (rst) lp_q <= 1'b0;
        else     lp_q <= line_pulse;
    end

    assign shift     = lp_q & ~line_pulse;
    assign mode.up   = scan_up;
    assign mode.dual = dual_half;
endmodule

// File: rtl/row_scan_pins.sv
module row_scan_pins
    import row_scan_pkg::*;
#(
    parameter int N_ROWS = 160
) (
    input  scan_mode_t           mode,
    input  logic [PIN_COUNT-1:0] pin_in,
    input  logic [N_ROWS-1:0]    stage_q,
    output logic                 in_lo,
    output logic                 in_hi,
    output logic                 in_mid,
    output logic [PIN_COUNT-1:0] pin_out,
    output logic [PIN_COUNT-1:0] pin_oe
);
    localparam int HALF = N_ROWS / 2;

    logic [PIN_COUNT-1:0] exits;

    assign in_lo  = pin_in[PIN_LO_END];
    assign in_hi  = pin_in[PIN_HI_END];
    assign in_mid = mode.up ? pin_in[PIN_MID_HI] : pin_in[PIN_MID_LO];

    assign exits[PIN_LO_END] = stage_q[0];
    assign exits[PIN_MID_LO] = stage_q[HALF-1];
    assign exits[PIN_MID_HI] = stage_q[HALF];
    assign exits[PIN_HI_END] = stage_q[N_ROWS-1];

    assign pin_oe  = pin_roles(mode);
    assign pin_out = exits & pin_oe;
endmodule

// File: rtl/row_scan_chain.sv
module row_scan_chain
    import row_scan_pkg::*;
#(
    parameter int N_ROWS = 160
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              shift,
    input  scan_mode_t        mode,
    input  logic              in_lo,
    input  logic              in_hi,
    input  logic              in_mid,
    output logic [N_ROWS-1:0] stage_q
);
    localparam int HALF = N_ROWS / 2;

    logic [N_ROWS-1:0] stage_d;

    for (genvar g = 0; g < N_ROWS; g++) begin : g_row
        logic from_below;
        logic from_above;

        if (g == 0) begin : g_lo
            assign from_below = in_lo;
        end else if (g == HALF) begin : g_mh
            assign from_below = mode.dual ? in_mid : stage_q[g-1];
        end else begin : g_pb
            assign from_below = stage_q[g-1];
        end

        if (g == N_ROWS-1) begin : g_hi
            assign from_above = in_hi;
        end else if (g == HALF-1) begin : g_ml
            assign from_above = mode.dual ? in_mid : stage_q[g+1];
        end else begin : g_pa
            assign from_above = stage_q[g+1];
        end

        assign stage_d[g] = mode.up ? from_below : from_above;
    end

    always_ff @(posedge clk) begin
        if (rst)        stage_q <= '0;
        else if (shift) stage_q <= stage_d;
    end
endmodule

// File: rtl/row_level_enc.sv
module row_level_enc
    import row_scan_pkg::*;
#(
    parameter int N_ROWS = 160
) (
    input  logic                stage_frame,
    input  logic                stage_on_n,
    input  logic [N_ROWS-1:0]   stage_q,
    output logic [2*N_ROWS-1:0] row_lvl
);
    for (genvar g = 0; g < N_ROWS; g++) begin : g_enc
        assign row_lvl[2*g +: 2] = row_encode(stage_frame, stage_q[g], stage_on_n);
    end
endmodule

// File: rtl/lcd_row_scan.sv
module lcd_row_scan
    import row_scan_pkg::*;
#(
    parameter int N_ROWS = 160
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  line_pulse,
    input  logic                  scan_up,
    input  logic                  dual_half,
    input  logic                  frame,
    input  logic                  blank_n,
    input  logic [3:0]            pin_in,
    output logic [3:0]            pin_out,
    output logic [3:0]            pin_oe,
    output logic [2*N_ROWS-1:0]   row_lvl
);
    logic              shift;
    scan_mode_t        mode;
    logic              in_lo;
    logic              in_hi;
    logic              in_mid;
    logic [N_ROWS-1:0] stage_q;

    row_scan_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .line_pulse (line_pulse),
        .scan_up    (scan_up),
        .dual_half  (dual_half),
        .shift      (shift),
        .mode       (mode)
    );

    row_scan_pins #(.N_ROWS(N_ROWS)) u_pins (
        .mode    (mode),
        .pin_in  (pin_in),
        .stage_q (stage_q),
        .in_lo   (in_lo),
        .in_hi   (in_hi),
        .in_mid  (in_mid),
        .pin_out (pin_out),
        .pin_oe  (pin_oe)
    );

    row_scan_chain #(.N_ROWS(N_ROWS)) u_chain (
        .clk     (clk),
        .rst     (rst),
        .shift   (shift),
        .mode    (mode),
        .in_lo   (in_lo),
        .in_hi   (in_hi),
        .in_mid  (in_mid),
        .stage_q (stage_q)
    );

    row_level_enc #(.N_ROWS(N_ROWS)) u_enc (
        .stage_frame (frame),
        .stage_on_n  (blank_n),
        .stage_q     (stage_q),
        .row_lvl     (row_lvl)
    );
endmodule

// File: rtl/row_scan_chk.sv
module row_scan_chk #(
    parameter int N_ROWS = 160
) (
    input logic                clk,
    input logic                rst,
    input logic                line_pulse,
    input logic                scan_up,
    input logic                dual_half,
    input logic                blank_n,
    input logic [3:0]          pin_in,
    input logic [3:0]          pin_out,
    input logic [3:0]          pin_oe,
    input logic [2*N_ROWS-1:0] row_lvl,
    input logic [N_ROWS-1:0]   stages
);
    localparam int HALF = N_ROWS / 2;

    logic lp_d;
    logic fall;

    always_ff @(posedge clk) begin
        if (rst) lp_d <= 1'b0;
        else     lp_d <= line_pulse;
    end
    assign fall = lp_d & ~line_pulse;

    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (stages == '0));

    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !fall |=> $stable(stages));

    p_entry_up_r3: assert property (@(posedge clk) disable iff (rst)
        (fall && scan_up && !dual_half) |=> (stages[0] == $past(pin_in[0])));

    p_entry_down_r4: assert property (@(posedge clk) disable iff (rst)
        (fall && !scan_up && !dual_half) |=> (stages[N_ROWS-1] == $past(pin_in[3])));

    p_split_up_r5: assert property (@(posedge clk) disable iff (rst)
        (fall && scan_up && dual_half) |=> (stages[HALF] == $past(pin_in[2])));

    p_split_down_r6: assert property (@(posedge clk) disable iff (rst)
        (fall && !scan_up && dual_half) |=> (stages[HALF-1] == $past(pin_in[1])));

    p_blank_r8: assert property (@(posedge clk) disable iff (rst)
        !blank_n |-> (row_lvl == '1));

    p_oe_count_r9: assert property (@(posedge clk) disable iff (rst)
        $countones(pin_oe) == (dual_half ? 2 : 1));

    p_out_masked_r9: assert property (@(posedge clk) disable iff (rst)
        (pin_out & ~pin_oe) == 4'b0000);
endmodule

bind lcd_row_scan row_scan_chk #(.N_ROWS(N_ROWS)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .line_pulse (line_pulse),
    .scan_up    (scan_up),
    .dual_half  (dual_half),
    .blank_n    (blank_n),
    .pin_in     (pin_in),
    .pin_out    (pin_out),
    .pin_oe     (pin_oe),
    .row_lvl    (row_lvl),
    .stages     (stage_q)
);

// File: tb/lcd_row_scan_tb.sv
module lcd_row_scan_tb;
    localparam int N = 160;
    localparam int H = N / 2;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           line_pulse = 1'b0;
    logic           scan_up = 1'b1;
    logic           dual_half = 1'b0;
    logic           frame = 1'b0;
    logic           blank_n = 1'b1;
    logic [3:0]     pin_in = 4'b0000;
    logic [3:0]     pin_out;
    logic [3:0]     pin_oe;
    logic [2*N-1:0] row_lvl;

    logic [N-1:0] mdl;
    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    lcd_row_scan #(.N_ROWS(N)) u_dut (
        .clk(clk), .rst(rst), .line_pulse(line_pulse), .scan_up(scan_up),
        .dual_half(dual_half), .frame(frame), .blank_n(blank_n),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .row_lvl(row_lvl)
    );

    task automatic chk(input string tag, input logic [2*N-1:0] act, input logic [2*N-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [1:0] code_of(input logic f, input logic b, input logic on_n);
        if (!on_n) return 2'd3;
        if (!f) return b ? 2'd0 : 2'd2;
        return b ? 2'd3 : 2'd1;
    endfunction

    task automatic check_all(input string tag);
        logic [3:0] eoe;
        logic [3:0] eout;
        logic [2*N-1:0] elvl;
        if (dual_half) eoe = scan_up ? 4'b1010 : 4'b0101;
        else           eoe = scan_up ? 4'b1000 : 4'b0001;
        eout = {eoe[3] & mdl[N-1], eoe[2] & mdl[H], eoe[1] & mdl[H-1], eoe[0] & mdl[0]};
        for (int i = 0; i < N; i++) elvl[2*i +: 2] = code_of(frame, mdl[i], blank_n);
        chk({tag, " R9 pin_oe"}, {{(2*N-4){1'b0}}, pin_oe}, {{(2*N-4){1'b0}}, eoe});
        chk({tag, " pin_out"}, {{(2*N-4){1'b0}}, pin_out}, {{(2*N-4){1'b0}}, eout});
        chk({tag, " R7 row_lvl"}, row_lvl, elvl);
    endtask

    task automatic do_shift(input string tag, input logic [3:0] pins);
        logic [N-1:0] nm;
        @(negedge clk) line_pulse = 1'b1;
        @(negedge clk) begin line_pulse = 1'b0; pin_in = pins; end
        @(negedge clk);
        if (scan_up) begin
            for (int i = N-1; i > 0; i--) nm[i] = mdl[i-1];
            nm[0] = pins[0];
            if (dual_half) nm[H] = pins[2];
        end else begin
            for (int i = 0; i < N-1; i++) nm[i] = mdl[i+1];
            nm[N-1] = pins[3];
            if (dual_half) nm[H-1] = pins[1];
        end
        mdl = nm;
        check_all(tag);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        mdl = '0;
        @(negedge clk);
        check_all("R1 reset");
        chk("R1 no selected row", row_lvl, {N{2'd2}});
    endtask

    task automatic t_single_up();
        scan_up = 1'b1; dual_half = 1'b0;
        do_shift("R3 R11 single up", 4'b1111);
        for (int k = 1; k < N; k++) do_shift("R3 R11 single up", 4'b1110);
        chk("R3 token at far end", {{(2*N-4){1'b0}}, pin_out}, {{(2*N-4){1'b0}}, 4'b1000});
        do_shift("R3 token leaves", 4'b1110);
        chk("R3 chain empty", {{(2*N-4){1'b0}}, pin_out}, '0);
    endtask

    task automatic t_hold();
        scan_up = 1'b1; dual_half = 1'b0;
        do_shift("R2 load", 4'b0001);
        do_shift("R2 load", 4'b0001);
        @(negedge clk) begin line_pulse = 1'b1; pin_in = 4'b1111; end
        repeat (4) @(negedge clk);
        check_all("R2 high hold");
        @(negedge clk) line_pulse = 1'b0;
        line_pulse = 1'b1;
        @(negedge clk) line_pulse = 1'b1;
        @(negedge clk);
        check_all("R2 no fall");
        @(negedge clk) begin line_pulse = 1'b0; pin_in = 4'b0000; end
        @(negedge clk);
        mdl = {mdl[N-2:0], 1'b0};
        check_all("R2 fall shifts");
        rst = 1'b1; @(negedge clk); rst = 1'b0; mdl = '0;
        @(negedge clk);
        check_all("R1 mid-run reset");
    endtask

    task automatic t_single_down();
        scan_up = 1'b0; dual_half = 1'b0;
        do_shift("R4 R11 single down", 4'b1111);
        for (int k = 1; k < N; k++) do_shift("R4 R11 single down", 4'b0111);
        chk("R4 token at row 1 end", {{(2*N-4){1'b0}}, pin_out}, {{(2*N-4){1'b0}}, 4'b0001});
        do_shift("R4 token leaves", 4'b0111);
    endtask

    task automatic t_dual_up();
        scan_up = 1'b1; dual_half = 1'b1;
        for (int k = 0; k < H + 2; k++)
            do_shift("R5 R11 dual up", (k == 0) ? 4'b1011 : (k == 2) ? 4'b1110 : 4'b1010);
        chk("R5 halves independent", {{(2*N-4){1'b0}}, pin_out}, {{(2*N-4){1'b0}}, 4'b1000});
    endtask

    task automatic t_dual_down();
        scan_up = 1'b0; dual_half = 1'b1;
        for (int k = 0; k < H; k++)
            do_shift("R6 R11 dual down", (k == 0) ? 4'b1101 : (k == 1) ? 4'b0111 : 4'b0101);
        chk("R6 upper exit", {{(2*N-4){1'b0}}, pin_out}, {{(2*N-4){1'b0}}, 4'b0100});
        do_shift("R6 dual down", 4'b0101);
        chk("R6 lower exit", {{(2*N-4){1'b0}}, pin_out}, {{(2*N-4){1'b0}}, 4'b0001});
    endtask

    task automatic t_levels();
        scan_up = 1'b1; dual_half = 1'b0;
        do_shift("R7 load", 4'b0001);
        do_shift("R7 load", 4'b0000);
        do_shift("R7 load", 4'b0001);
        @(negedge clk) frame = 1'b0; @(negedge clk);
        check_all("R7 frame 0");
        chk("R7 row0 f0 sel", {{(2*N-2){1'b0}}, row_lvl[1:0]}, {{(2*N-2){1'b0}}, 2'd0});
        chk("R7 row1 f0 idle", {{(2*N-2){1'b0}}, row_lvl[3:2]}, {{(2*N-2){1'b0}}, 2'd2});
        @(negedge clk) frame = 1'b1; @(negedge clk);
        check_all("R7 frame 1");
        chk("R7 row0 f1 sel", {{(2*N-2){1'b0}}, row_lvl[1:0]}, {{(2*N-2){1'b0}}, 2'd3});
        chk("R7 row1 f1 idle", {{(2*N-2){1'b0}}, row_lvl[3:2]}, {{(2*N-2){1'b0}}, 2'd1});
    endtask

    task automatic t_blank();
        @(negedge clk) blank_n = 1'b0;
        do_shift("R8 blank shift", 4'b0001);
        chk("R8 all bottom", row_lvl, '1);
        @(negedge clk) blank_n = 1'b1; @(negedge clk);
        check_all("R8 rows restored");
        frame = 1'b0;
    endtask

    task automatic t_mode_switch();
        @(negedge clk) begin scan_up = 1'b1; dual_half = 1'b1; end
        @(negedge clk);
        check_all("R10 switch no reorder");
        do_shift("R10 dual up", 4'b0101);
        @(negedge clk) begin scan_up = 1'b0; dual_half = 1'b0; end
        @(negedge clk);
        check_all("R10 switch back");
        for (int k = 0; k < 4; k++) do_shift("R10 single down", 4'b0000);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        mdl = '0;
        t_reset();
        t_single_up();
        t_hold();
        t_single_down();
        t_dual_up();
        t_dual_down();
        t_levels();
        t_blank();
        t_mode_switch();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule